// File: doc/BRIEF.md
# Nibble Logic-Operation Execute Unit

This block is the decode and execute stage for the logic instructions of a 4-bit microcontroller core. It accepts one 13-bit instruction word at a time. It performs four kinds of work:

- exclusive-OR into a register, into the flag register or into data memory;
- a flag-only AND (bit test);
- single-bit clear or set on data memory;
- single-bit test on data memory.

It holds two 4-bit data registers (A and B), a 4-bit flag register and two 16-bit index registers (X and Y). Each index register can be post-incremented.

Data memory sits behind a plain port. The address is driven combinationally. Read data is expected back in the same cycle. A write commits on the clock edge while the write strobe is high.

Most instructions finish in the cycle they are accepted. Forms that write memory take a second cycle. A `done` pulse marks the final cycle of every legal instruction. An unknown word raises `illegal` for one cycle and changes nothing. Fetch, prefixing and all other instruction classes are handled elsewhere in the core.

Top module: `nibble_logic_exec`

## Requirements
- R1: After reset A, B and the flags are 0, X and Y hold their `X_INIT`/`Y_INIT` parameter values, `ready` is 1 and `done`, `illegal` and `mem_we` are 0.
- R2: The register group is a word with bits 12..7 = 110111 (exclusive-OR) or 110101 (bit test). In that group, bits 6..4 = 100 or 101 combine A or B with the immediate in bits 3..0. Bits 6..3 = 1110 combine destination (bit 2: 0 = A, 1 = B) with source (bit 1: 0 = A, 1 = B), and bit 0 is ignored. An exclusive-OR of this kind writes the destination, sets Z (flag bit 0) when the result is 0, leaves flag bits 3..1 unchanged, and finishes in one cycle.
- R3: Bits 6..3 = 1100 take the source from memory. Bit 2 picks the destination (A/B), bit 1 picks Y instead of X as the address, and bit 0 asks for post-increment. The instruction finishes in one cycle.
- R4: In the exclusive-OR group, a memory destination takes two cycles. It is selected by bits 6..3 = 1101, with bit 2 picking source B over A, bit 1 picking Y and bit 0 asking for post-increment. It is also selected by bit 6 = 0 with an immediate in bits 3..0, where bit 5 picks Y and bit 4 asks for post-increment. The first cycle does not write. The second cycle drives `mem_we` with the result at the same address, and Z is updated at its end.
- R5: Word bits 12..4 = 100001010 loads the flag register with its old value XOR bits 3..0. All four flag bits are written. The flag order is bit 3 E, bit 2 I, bit 1 C, bit 0 Z.
- R6: The bit-test group (bits 12..7 = 110101) has the same operand layout as R2–R4. It updates only Z, from the AND of the two operands. It never writes a register or memory and always finishes in one cycle.
- R7: Words 1010 and 1011 in bits 12..9 clear or set one bit of a directly addressed location. The bit number is in bits 7..6. The address is `LOW_PAGE`:00:offset when bit 8 is 0 and `HIGH_PAGE`:00:offset when bit 8 is 1, with the offset in bits 5..0. These take two cycles, write in the second cycle and leave all flags unchanged.
- R8: Bits 12..9 = 1001 test the same direct bit. Z is set when that bit is 0. Nothing else changes, and the instruction finishes in one cycle.
- R9: Post-increment adds 1 modulo 2^16 to the selected index register after the access, which uses the old value. An index register changes only by post-increment.
- R10: `done` is high in the final cycle of each legal instruction. `ready` is low in the second cycle of a two-cycle instruction, and a word offered in that cycle is ignored.
- R11: Any other word raises `illegal` for that one cycle, does not raise `done`, does not write memory and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered this cycle |
| instr | input | 13 | Instruction word |
| ready | output | 1 | Unit accepts a word this cycle |
| done | output | 1 | Final cycle of a legal instruction |
| illegal | output | 1 | Offered word is not recognised |
| mem_addr | output | AW | Data memory address |
| mem_rdata | input | DW | Data memory read data, same cycle |
| mem_we | output | 1 | Write strobe, commits at the clock edge |
| mem_wdata | output | DW | Data memory write data |
| reg_a | output | DW | Register A |
| reg_b | output | DW | Register B |
| reg_f | output | DW | Flag register {E, I, C, Z} |
| reg_x | output | AW | Index register X |
| reg_y | output | AW | Index register Y |

## Verification
The exclusive-OR is tried with several operand pairs:

- immediate, register and memory sources;
- a register combined with itself, which gives zero and sets Z;
- operands whose result is not zero, which clears Z.

These cases show that the right source and destination are chosen and that Z tracks the result. A flag load that sets the upper flag bits, followed by further operations, shows that only Z moves. Memory-destination and bit clear/set words are issued back to back. A decoy word is offered during their second cycle to show the write timing and that the decoy is ignored. Index Y starts two below the top of the address space, so post-increment wrapping is seen. Illegal words near legal encodings show that nothing changes.

// File: rtl/nlx_pkg.sv
package nlx_pkg;

   localparam int NIB_W  = 4;
   localparam int INSN_W = 13;
   localparam int OFF_W  = 6;

   localparam int FLG_Z = 0;

   localparam logic [5:0] GRP_XOR = 6'b110111;
   localparam logic [5:0] GRP_BIT = 6'b110101;
   localparam logic [8:0] FLAG_XOR_HDR = 9'b100001010;

   typedef enum logic [2:0] {
      LOP_XOR,
      LOP_AND,
      LOP_CLR,
      LOP_SET,
      LOP_TST
   } lop_e;

   typedef enum logic [1:0] {
      OPD_A,
      OPD_B,
      OPD_IMM,
      OPD_MEM
   } src_e;

   typedef enum logic [1:0] {
      TGT_A,
      TGT_B,
      TGT_F,
      TGT_MEM
   } tgt_e;

   typedef struct packed {
      logic              legal;
      lop_e              op;
      tgt_e              tgt;
      src_e              src;
      logic              mem_use;
      logic              direct;
      logic              use_y;
      logic              post_inc;
      logic              two_cyc;
      logic [NIB_W-1:0]  imm;
      logic              page_hi;
      logic [OFF_W-1:0]  off;
   } dec_t;

endpackage

// File: rtl/nlx_decode.sv
module nlx_decode
   import nlx_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output dec_t              d
);

   always_comb begin
      d          = '0;
      d.op       = LOP_XOR;
      d.tgt      = TGT_A;
      d.src      = OPD_IMM;
      d.imm      = insn[3:0];
      d.page_hi  = insn[8];
      d.off      = insn[5:0];
      if (insn[12:7] == GRP_XOR || insn[12:7] == GRP_BIT) begin
         d.legal = 1'b1;
         d.op    = insn[8] ? LOP_XOR : LOP_AND;
         casez (insn[6:0])
            7'b10?????: begin
               d.tgt = insn[4] ? TGT_B : TGT_A;
               d.src = OPD_IMM;
            end
            7'b1110???: begin
               d.tgt = insn[2] ? TGT_B : TGT_A;
               d.src = insn[1] ? OPD_B : OPD_A;
            end
            7'b1100???: begin
               d.tgt      = insn[2] ? TGT_B : TGT_A;
               d.src      = OPD_MEM;
               d.mem_use  = 1'b1;
               d.use_y    = insn[1];
               d.post_inc = insn[0];
            end
            7'b1101???: begin
               d.tgt      = TGT_MEM;
               d.src      = insn[2] ? OPD_B : OPD_A;
               d.mem_use  = 1'b1;
               d.use_y    = insn[1];
               d.post_inc = insn[0];
            end
            7'b0??????: begin
               d.tgt      = TGT_MEM;
               d.src      = OPD_IMM;
               d.mem_use  = 1'b1;
               d.use_y    = insn[5];
               d.post_inc = insn[4];
            end
            default: d.legal = 1'b0;
         endcase
         d.two_cyc = d.legal && (d.tgt == TGT_MEM) && (d.op == LOP_XOR);
      end else if (insn[12:4] == FLAG_XOR_HDR) begin
         d.legal = 1'b1;
         d.tgt   = TGT_F;
         d.src   = OPD_IMM;
      end else if (insn[12:11] == 2'b10 && insn[10:9] != 2'b00) begin
         d.legal   = 1'b1;
         d.tgt     = TGT_MEM;
         d.src     = OPD_IMM;
         d.mem_use = 1'b1;
         d.direct  = 1'b1;
         d.imm     = NIB_W'(1) << insn[7:6];
         case (insn[10:9])
            2'b10:   d.op = LOP_CLR;
            2'b11:   d.op = LOP_SET;
            default: d.op = LOP_TST;
         endcase
         d.two_cyc = (d.op != LOP_TST);
      end
   end

endmodule

// File: rtl/nlx_logic.sv
module nlx_logic
   import nlx_pkg::*;
#(
   parameter int W = 4
) (
   input  lop_e         op,
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   output logic [W-1:0] res,
   output logic         zero
);

   if (W < 1) begin : g_bad_w
      $error("nlx_logic: W must be positive");
   end

   always_comb begin
      case (op)
         LOP_XOR: res = lhs ^ rhs;
         LOP_CLR: res = lhs & ~rhs;
         LOP_SET: res = lhs | rhs;
         default: res = lhs & rhs;
      endcase
   end

   assign zero = ~|res;

endmodule

// File: rtl/nlx_index.sv
module nlx_index #(
   parameter int            AW   = 16,
   parameter logic [AW-1:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [AW-1:0] value
);

   if (AW < 2) begin : g_bad_aw
      $error("nlx_index: AW too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= INIT;
      else if (inc) value <= value + 1'b1;
   end

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> value == $past(value) + 1'b1);   // R9
   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(value));                // R9

endmodule

// File: rtl/nibble_logic_exec.sv
module nibble_logic_exec
   import nlx_pkg::*;
#(
   parameter int              AW        = 16,
   parameter int              DW        = 4,
   parameter logic [AW-1:0]   X_INIT    = '0,
   parameter logic [AW-1:0]   Y_INIT    = '0,
   parameter logic [AW-9:0]   LOW_PAGE  = '0,
   parameter logic [AW-9:0]   HIGH_PAGE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [12:0]       instr,
   output logic              ready,
   output logic              done,
   output logic              illegal,
   output logic [AW-1:0]     mem_addr,
   input  logic [DW-1:0]     mem_rdata,
   output logic              mem_we,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW-1:0]     reg_a,
   output logic [DW-1:0]     reg_b,
   output logic [DW-1:0]     reg_f,
   output logic [AW-1:0]     reg_x,
   output logic [AW-1:0]     reg_y
);

   localparam int N_IDX = 2;
   localparam int PAD_W = 8 - OFF_W;

   if (DW != NIB_W) begin : g_bad_dw
      $error("nibble_logic_exec: DW must equal the nibble width");
   end
   if (AW < 9) begin : g_bad_aw
      $error("nibble_logic_exec: AW must leave room for a page byte");
   end

   dec_t            d;
   logic            busy_q;
   logic            issue, ok, start, fin_one;
   logic [DW-1:0]   a_q, b_q, f_q;
   logic [DW-1:0]   lhs, rhs, res;
   logic            zero;
   logic [AW-1:0]   idx_val [N_IDX];
   logic [N_IDX-1:0] idx_inc, inc_q;
   logic [AW-1:0]   dir_addr, cur_addr, addr_q;
   logic [DW-1:0]   data_q;
   logic            z_q, zupd_q;

   nlx_decode i_dec (
      .insn (instr),
      .d    (d)
   );

   assign issue   = instr_valid && !busy_q;
   assign ok      = issue && d.legal;
   assign start   = ok && d.two_cyc;
   assign fin_one = ok && !d.two_cyc;

   // operand selection
   always_comb begin
      case (d.tgt)
         TGT_A:   lhs = a_q;
         TGT_B:   lhs = b_q;
         TGT_F:   lhs = f_q;
         default: lhs = mem_rdata;
      endcase
      case (d.src)
         OPD_A:   rhs = a_q;
         OPD_B:   rhs = b_q;
         OPD_MEM: rhs = mem_rdata;
         default: rhs = d.imm;
      endcase
   end

   nlx_logic #(.W(DW)) i_logic (
      .op   (d.op),
      .lhs  (lhs),
      .rhs  (rhs),
      .res  (res),
      .zero (zero)
   );

   // index registers, one slice per pointer
   for (genvar k = 0; k < N_IDX; k++) begin : g_idx
      localparam logic [AW-1:0] INIT_K = (k == 0) ? X_INIT : Y_INIT;
      logic sel_k;
      assign sel_k      = (d.use_y == (k == 1));
      assign idx_inc[k] = (fin_one && d.mem_use && d.post_inc && sel_k)
                        || (busy_q && inc_q[k]);
      nlx_index #(.AW(AW), .INIT(INIT_K)) i_index (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (idx_inc[k]),
         .value (idx_val[k])
      );
   end

   assign dir_addr = {(d.page_hi ? HIGH_PAGE : LOW_PAGE), {PAD_W{1'b0}}, d.off};
   assign cur_addr = d.direct ? dir_addr : (d.use_y ? idx_val[1] : idx_val[0]);

   // data and flag registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         f_q <= '0;
      end else if (busy_q) begin
         if (zupd_q) f_q[FLG_Z] <= z_q;
      end else if (fin_one) begin
         if (d.tgt == TGT_F) begin
            f_q <= res;
         end else begin
            f_q[FLG_Z] <= zero;
            if (d.op == LOP_XOR && d.tgt == TGT_A) a_q <= res;
            if (d.op == LOP_XOR && d.tgt == TGT_B) b_q <= res;
         end
      end
   end

   // second-cycle write state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         z_q    <= 1'b0;
         zupd_q <= 1'b0;
         inc_q  <= '0;
      end else begin
         busy_q <= start;
         if (start) begin
            addr_q <= cur_addr;
            data_q <= res;
            z_q    <= zero;
            zupd_q <= (d.op == LOP_XOR);
            inc_q  <= {d.post_inc && d.use_y, d.post_inc && !d.use_y};
         end
      end
   end

   assign ready     = !busy_q;
   assign done      = fin_one || busy_q;
   assign illegal   = issue && !d.legal;
   assign mem_we    = busy_q;
   assign mem_wdata = data_q;
   assign mem_addr  = busy_q ? addr_q : cur_addr;
   assign reg_a     = a_q;
   assign reg_b     = b_q;
   assign reg_f     = f_q;
   assign reg_x     = idx_val[0];
   assign reg_y     = idx_val[1];

   AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);                                          // R10
   AST_WRITE_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == $past(cur_addr));                      // R4
   AST_ILLEGAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> ($stable(a_q) && $stable(b_q) && $stable(f_q)
                   && $stable(reg_x) && $stable(reg_y)));           // R11
   AST_ILLEGAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !done && !mem_we);                                // R11

endmodule

// File: tb/test_nibble_logic_exec.sv
module test_nibble_logic_exec;

   localparam logic [15:0] XI = 16'h0100;
   localparam logic [15:0] YI = 16'hFFFE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [12:0] instr = '0;
   logic        ready, done, illegal, mem_we;
   logic [15:0] mem_addr, reg_x, reg_y;
   logic [3:0]  mem_rdata, mem_wdata, reg_a, reg_b, reg_f;

   logic [3:0]  memory [0:1023];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          cyc = 0;

   always #5 clk = ~clk;

   nibble_logic_exec #(.AW(16), .DW(4), .X_INIT(XI), .Y_INIT(YI)) i_nibble_logic_exec (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .ready(ready), .done(done), .illegal(illegal),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .reg_a(reg_a), .reg_b(reg_b), .reg_f(reg_f), .reg_x(reg_x), .reg_y(reg_y)
   );

   function automatic logic [9:0] slot(input logic [15:0] a);
      return {a[15], a[8:0]};
   endfunction

   assign mem_rdata = memory[slot(mem_addr)];
   always @(posedge clk) if (mem_we) memory[slot(mem_addr)] <= mem_wdata;

   // reference model state
   logic [3:0]  ma = 0, mb = 0, mf = 0, na, nb, nf;
   logic [15:0] mx = XI, my = YI, nx, ny;
   bit          mbusy = 0, nbusy;
   logic [15:0] paddr, npaddr;
   logic [3:0]  pdata, npdata;
   bit          pz, pzu, pix, piy, npz, npzu, npix, npiy;
   bit          e_ready, e_done, e_ill, e_we;
   logic [15:0] e_addr;
   logic [3:0]  e_wd;
   string       busy_tag;

   task automatic predict(input bit v, input logic [12:0] ins);
      logic [3:0]  lv, rv, mv, res;
      logic [15:0] ad;
      int          tg, kind;
      bit          good, usemem, yy, pp, dir, two;
      e_ready = !mbusy; e_done = 0; e_ill = 0; e_we = 0; e_addr = 0; e_wd = 0;
      na = ma; nb = mb; nf = mf; nx = mx; ny = my; nbusy = 0;
      npaddr = paddr; npdata = pdata; npz = pz; npzu = pzu; npix = pix; npiy = piy;
      if (mbusy) begin
         e_done = 1; e_we = 1; e_addr = paddr; e_wd = pdata;
         if (pzu) nf[0] = pz;
         if (pix) nx = mx + 16'd1;
         if (piy) ny = my + 16'd1;
      end else if (v) begin
         good = 1; usemem = 0; yy = 0; pp = 0; dir = 0; tg = 0; kind = 0;
         rv = ins[3:0]; ad = 0;
         if (ins[12:7] == 6'b110111 || ins[12:7] == 6'b110101) begin
            kind = ins[8] ? 0 : 1;
            if (ins[6:5] == 2'b10) tg = ins[4] ? 1 : 0;
            else if (ins[6:3] == 4'b1110) begin
               tg = ins[2] ? 1 : 0; rv = ins[1] ? mb : ma;
            end else if (ins[6:3] == 4'b1100) begin
               tg = ins[2] ? 1 : 0; usemem = 1; yy = ins[1]; pp = ins[0];
            end else if (ins[6:3] == 4'b1101) begin
               tg = 3; rv = ins[2] ? mb : ma; usemem = 1; yy = ins[1]; pp = ins[0];
            end else if (!ins[6]) begin
               tg = 3; usemem = 1; yy = ins[5]; pp = ins[4];
            end else good = 0;
         end else if (ins[12:4] == 9'h10A) begin
            tg = 2;
         end else if (ins[12:11] == 2'b10 && ins[10:9] != 2'b00) begin
            tg = 3; dir = 1; usemem = 1;
            kind = (ins[10:9] == 2'b10) ? 2 : (ins[10:9] == 2'b11) ? 3 : 4;
            rv = 4'(1 << ins[7:6]);
            ad = {(ins[8] ? 8'hFF : 8'h00), 2'b00, ins[5:0]};
         end else good = 0;
         if (!good) e_ill = 1;
         else begin
            if (usemem && !dir) ad = yy ? my : mx;
            mv = memory[slot(ad)];
            lv = (tg == 0) ? ma : (tg == 1) ? mb : (tg == 2) ? mf : mv;
            if (tg < 2 && usemem) rv = mv;
            case (kind)
               0:       res = lv ^ rv;
               2:       res = lv & ~rv;
               3:       res = lv | rv;
               default: res = lv & rv;
            endcase
            two = (tg == 3) && (kind == 0 || kind == 2 || kind == 3);
            if (two) begin
               nbusy = 1; npaddr = ad; npdata = res; npz = (res == 0);
               npzu = (kind == 0); npix = pp && !yy; npiy = pp && yy;
            end else begin
               e_done = 1;
               if (kind == 0 && tg == 2) nf = res;
               else begin
                  nf[0] = (res == 0);
                  if (kind == 0 && tg == 0) na = res;
                  if (kind == 0 && tg == 1) nb = res;
               end
               if (pp) begin
                  if (yy) ny = my + 16'd1;
                  else    nx = mx + 16'd1;
               end
            end
         end
      end
   endtask

   task automatic chk(input string tag, input string nm, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "ready", 16'(ready), 16'(e_ready));
      chk(tag, "done", 16'(done), 16'(e_done));
      chk(tag, "illegal", 16'(illegal), 16'(e_ill));
      chk(tag, "mem_we", 16'(mem_we), 16'(e_we));
      if (e_we) begin
         chk(tag, "mem_addr", mem_addr, e_addr);
         chk(tag, "mem_wdata", 16'(mem_wdata), 16'(e_wd));
      end
      chk(tag, "reg_a", 16'(reg_a), 16'(ma));
      chk(tag, "reg_b", 16'(reg_b), 16'(mb));
      chk(tag, "reg_f", 16'(reg_f), 16'(mf));
      chk(tag, "reg_x", reg_x, mx);
      chk(tag, "reg_y", reg_y, my);
   endtask

   task automatic step(input bit v, input logic [12:0] ins, input string tag);
      instr_valid = v; instr = ins;
      @(negedge clk);
      predict(v, ins);
      compare(tag);
      @(posedge clk);
      ma = na; mb = nb; mf = nf; mx = nx; my = ny; mbusy = nbusy;
      paddr = npaddr; pdata = npdata; pz = npz; pzu = npzu; pix = npix; piy = npiy;
      #1;
   endtask

   // issue one word; while the unit is busy a decoy word is offered (R10)
   task automatic run(input logic [12:0] ins, input string tag);
      step(1'b1, ins, tag);
      busy_tag = {tag, "/R10"};
      while (mbusy) step(1'b1, {6'b110111, 3'b100, 4'hF}, busy_tag);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog R10: actual %0d cycles expected under 20000", cyc);
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) memory[i] = 4'h0;
      memory[slot(16'h0100)] = 4'h6;
      memory[slot(16'h0101)] = 4'h9;
      memory[slot(16'h0102)] = 4'h3;
      memory[slot(16'h0103)] = 4'hE;
      memory[slot(16'hFFFE)] = 4'hA;
      memory[slot(16'hFFFF)] = 4'h5;
      memory[slot(16'h0000)] = 4'hC;
      memory[slot(16'h0005)] = 4'b1010;
      memory[slot(16'hFF3F)] = 4'b0110;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      step(1'b0, 13'h0000, "R1");
      // register-destination exclusive-OR
      run({6'b110111, 3'b100, 4'h5}, "R2");
      run({6'b110111, 3'b101, 4'hC}, "R2");
      run({6'b110111, 7'b1110010}, "R2");
      run({6'b110111, 7'b1110110}, "R2");
      run({6'b110111, 7'b1110001}, "R2");
      run({6'b110111, 3'b100, 4'h7}, "R2");
      // memory source
      run({6'b110111, 7'b1100001}, "R3");
      run({6'b110111, 7'b1100111}, "R3");
      run({6'b110111, 7'b1100000}, "R3");
      // memory destination
      run({6'b110111, 7'b1101101}, "R4");
      run({6'b110111, 3'b011, 4'h5}, "R4");
      run({6'b110111, 7'b1100011}, "R9");
      run({6'b110111, 3'b000, 4'h9}, "R4");
      run({6'b110111, 7'b1101000}, "R4");
      // flag register load
      run({9'b100001010, 4'hE}, "R5");
      run({6'b110111, 3'b100, 4'h3}, "R5");
      run({9'b100001010, 4'h6}, "R5");
      // bit-test group
      run({6'b110101, 3'b100, 4'h0}, "R6");
      run({6'b110101, 3'b101, 4'hF}, "R6");
      run({6'b110101, 7'b1110010}, "R6");
      run({6'b110101, 3'b001, 4'hF}, "R6");
      run({6'b110101, 7'b1101001}, "R6");
      run({6'b110101, 7'b1100100}, "R6");
      // direct single-bit operations
      run({4'b1010, 1'b0, 2'd1, 6'd5}, "R7");
      run({4'b1011, 1'b1, 2'd0, 6'h3F}, "R7");
      run({4'b1001, 1'b1, 2'd3, 6'h3F}, "R8");
      run({4'b1001, 1'b0, 2'd3, 6'd5}, "R8");
      run({4'b1001, 1'b0, 2'd1, 6'd5}, "R8");
      run({4'b1011, 1'b0, 2'd2, 6'd5}, "R7");
      run({4'b1010, 1'b1, 2'd1, 6'h3F}, "R7");
      run({4'b1001, 1'b1, 2'd1, 6'h3F}, "R8");
      // illegal words
      run(13'h0000, "R11");
      run({6'b110111, 7'b1111000}, "R11");
      run(13'b1000000000000, "R11");
      run({9'b100001011, 4'h3}, "R11");
      run({6'b110101, 7'b1111111}, "R11");
      // back-to-back two-cycle words, then idle
      run({6'b110111, 3'b010, 4'h6}, "R10");
      run({4'b1011, 1'b0, 2'd0, 6'd7}, "R10");
      run({6'b110111, 3'b101, 4'h1}, "R10");
      step(1'b0, 13'h0000, "R10");
      step(1'b0, 13'h0000, "R1");
      finish_run();
   end

endmodule